// File: doc/BRIEF.md
# Typed Multi-Channel Scatter Sequencer

The sequencer accepts one scatter-write command and expands it into an ordered stream of single-dword write requests to a typed surface store. Each command carries a lane-count field, a per-lane enable vector, a four-bit colour-channel mask, per-lane U/V/R coordinates and a packed source buffer. The sequencer steps through the enabled colour channels from lowest to highest. Within each channel it steps through the lanes. For every enabled lane it locates the lane's source word and presents address, channel number and data on a valid/ready write port.

Source words are packed per enabled channel, not per channel slot. Each enabled channel takes one block of `max(lanes, register dwords)` words, and a disabled lane still owns its word inside that block. Coordinates are checked against the surface dimensions that are latched with the command. A write that falls outside the surface is dropped without reaching the port. A one-cycle `done` pulse closes every command. An empty channel mask is rejected with an error flag, and no writes are made for it.

Top module: `scatter_seq`

## Requirements
- R1: The lane count is 2 to the power of `cmdExec[2:0]`, limited to MAX_LANES. Lanes at or above that count never produce a write.
- R2: When `cmdExec[7]` is 1, every lane below the lane count is enabled whatever `cmdLaneEn` holds. When it is 0, lane i is enabled only if `cmdLaneEn[i]` is 1.
- R3: Channel c is enabled by `cmdChMask[c]` (bit 0 R, bit 1 G, bit 2 B, bit 3 A). All writes of a lower channel come before any write of a higher one, and lanes within a channel go in ascending order. Only enabled lanes of enabled channels are written, each exactly once.
- R4: Lane i of the k-th enabled channel (k counted from 0, disabled channels not counted) takes source word `k*max(laneCount, REG_BYTES/4) + i`. Source word j sits at `cmdSrc[j*32 +: 32]`.
- R5: The write address is `((R*height + V)*width + U)*4 + c`, and `wrChan` carries c.
- R6: `surfDim` 2 selects a 2D surface and 3 selects a 3D surface; any other value selects 1D. On a 1D surface both V and R are ignored and taken as 0. On a 2D surface R is ignored and taken as 0.
- R7: A write is dropped when U >= width, when V >= height on a 2D or 3D surface, or when R >= depth on a 3D surface.
- R8: A command whose channel mask is 0000 produces no write. It ends with `cmdErr` high during its `done` cycle. `cmdErr` stays low for every other command.
- R9: While `wrValid` is high and `wrReady` is low, `wrValid`, `wrAddr`, `wrChan` and `wrData` hold their values into the next cycle.
- R10: `cmdReady` is high only while idle, and `cmdValid` has no effect while busy. `done` is a one-cycle pulse. It rises the cycle after the final slot is accepted or dropped, and the cycle after acceptance for an empty mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Sequencer idle, command taken this cycle if offered |
| cmdExec | input | 8 | Bits 2..0 lane-count code, bit 7 forces all lanes on |
| cmdLaneEn | input | MAX_LANES | Per-lane enable |
| cmdChMask | input | 4 | Colour-channel enable, R at bit 0 |
| cmdU | input | MAX_LANES*COORD_W | U coordinate per lane |
| cmdV | input | MAX_LANES*COORD_W | V coordinate per lane |
| cmdR | input | MAX_LANES*COORD_W | R coordinate per lane |
| cmdSrc | input | SRC_WORDS*DATA_W | Packed source words |
| surfDim | input | 2 | Surface dimensionality code |
| surfWidth | input | COORD_W | Surface width |
| surfHeight | input | COORD_W | Surface height |
| surfDepth | input | COORD_W | Surface depth |
| wrValid | output | 1 | Write request valid |
| wrReady | input | 1 | Write request accepted |
| wrAddr | output | 3*COORD_W+2 | Dword address of the write |
| wrChan | output | 2 | Channel of the write |
| wrData | output | DATA_W | Write data |
| done | output | 1 | Command finished (one-cycle pulse) |
| cmdErr | output | 1 | Empty channel mask, valid with done |

## Verification
The inline assertions check on every cycle that a stalled write holds its payload, that an empty mask leads straight to the error flag with no write, and that every issued address lies inside the latched surface. They also check that lanes above the lane count never write, that `done` lasts one cycle and that the block stops taking commands once it has accepted one. Only the bench scenarios, compared against a reference model of the write stream, can show the channel and lane ordering, the per-enabled-channel packing of source words, the coordinates that are ignored on 1D and 2D surfaces, the dropping of out-of-range writes and the exact cycle of `done`.

// File: rtl/scatter_pkg.sv
package scatter_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_FIN  = 2'd2
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic slotWrite;
    logic slotLast;
  } seqStatus_t;

  localparam logic [1:0] DIM_2D = 2'd2;
  localparam logic [1:0] DIM_3D = 2'd3;

endpackage

// File: rtl/scatter_seq_ctrl.sv
module scatter_seq_ctrl
  import scatter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdMaskZero,
  input  logic       wrReady,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       cmdReady,
  output logic       wrValid,
  output logic       done,
  output logic       cmdErr
);

  seqState_t state, stateNext;
  logic      errQ;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    cmdReady  = (state == SEQ_IDLE);
    wrValid   = (state == SEQ_RUN) && status.slotWrite;
    case (state)
      SEQ_IDLE: begin
        if (cmdValid) begin
          strobe.load = 1'b1;
          stateNext   = cmdMaskZero ? SEQ_FIN : SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        strobe.step = !status.slotWrite || wrReady;
        if (strobe.step && status.slotLast) stateNext = SEQ_FIN;
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.load) errQ <= cmdMaskZero;
    end
  end

  assign done   = (state == SEQ_FIN);
  assign cmdErr = done && errQ;

  // R10: the completion pulse never lasts two cycles
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: once a command is taken the block is busy on the next cycle
  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady |=> !cmdReady);

endmodule

// File: rtl/scatter_seq_dp.sv
module scatter_seq_dp
  import scatter_pkg::*;
#(
  parameter int MAX_LANES = 8,
  parameter int REG_BYTES = 32,
  parameter int COORD_W   = 8,
  parameter int DATA_W    = 32,
  localparam int REG_DW     = REG_BYTES / 4,
  localparam int STRIDE_MAX = (MAX_LANES > REG_DW) ? MAX_LANES : REG_DW,
  localparam int SRC_WORDS  = 4 * STRIDE_MAX,
  localparam int IDX_W      = $clog2(SRC_WORDS),
  localparam int LANE_W     = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
  localparam int CNT_W      = $clog2(MAX_LANES + 1),
  localparam int ADDR_W     = 3 * COORD_W + 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  seqStrobe_t                     strobe,
  input  logic [7:0]                     cmdExec,
  input  logic [MAX_LANES-1:0]           cmdLaneEn,
  input  logic [3:0]                     cmdChMask,
  input  logic [MAX_LANES*COORD_W-1:0]   cmdU,
  input  logic [MAX_LANES*COORD_W-1:0]   cmdV,
  input  logic [MAX_LANES*COORD_W-1:0]   cmdR,
  input  logic [SRC_WORDS*DATA_W-1:0]    cmdSrc,
  input  logic [1:0]                     surfDim,
  input  logic [COORD_W-1:0]             surfWidth,
  input  logic [COORD_W-1:0]             surfHeight,
  input  logic [COORD_W-1:0]             surfDepth,
  output seqStatus_t                     status,
  output logic [ADDR_W-1:0]              wrAddr,
  output logic [1:0]                     wrChan,
  output logic [DATA_W-1:0]              wrData
);

  // command decode at load time
  logic [CNT_W-1:0]     laneCntIn;
  logic [IDX_W-1:0]     strideIn;
  logic [MAX_LANES-1:0] enIn;

  always_comb begin
    int unsigned rawCnt;
    rawCnt = 32'd1 << cmdExec[2:0];
    if (rawCnt > MAX_LANES) rawCnt = MAX_LANES;
    laneCntIn = CNT_W'(rawCnt);
    strideIn  = IDX_W'((rawCnt > REG_DW) ? rawCnt : REG_DW);
  end

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_laneEn
    assign enIn[i] = (CNT_W'(i) < laneCntIn) && (cmdExec[7] || cmdLaneEn[i]);
  end

  // latched command
  logic [CNT_W-1:0]                 laneCntQ;
  logic [IDX_W-1:0]                 strideQ;
  logic [MAX_LANES-1:0]             enQ;
  logic [3:0]                       maskQ;
  logic [MAX_LANES*COORD_W-1:0]     uQ, vQ, rQ;
  logic [SRC_WORDS*DATA_W-1:0]      srcQ;
  logic [1:0]                       dimQ;
  logic [COORD_W-1:0]               wQ, hQ, dQ;

  // walk position
  logic [1:0]        chIdx;
  logic [1:0]        chPos;
  logic [LANE_W-1:0] lane;

  // current slot
  logic [COORD_W-1:0] uCur, vCur, rCur, vEff, rEff;
  logic               has2, has3, inBounds, chOn, laneLast;
  logic [IDX_W-1:0]   srcIdx;
  logic [ADDR_W-1:0]  linear;

  assign has2 = (dimQ == DIM_2D) || (dimQ == DIM_3D);
  assign has3 = (dimQ == DIM_3D);
  assign uCur = uQ[lane*COORD_W +: COORD_W];
  assign vCur = vQ[lane*COORD_W +: COORD_W];
  assign rCur = rQ[lane*COORD_W +: COORD_W];
  assign vEff = has2 ? vCur : '0;
  assign rEff = has3 ? rCur : '0;

  assign inBounds = (uCur < wQ) && (!has2 || (vCur < hQ)) && (!has3 || (rCur < dQ));
  assign chOn     = maskQ[chIdx];
  assign laneLast = (CNT_W'(lane) + CNT_W'(1)) == laneCntQ;

  assign status.slotWrite = chOn && enQ[lane] && inBounds;
  assign status.slotLast  = (chIdx == 2'd3) && (!chOn || laneLast);

  assign srcIdx = IDX_W'(chPos) * strideQ + IDX_W'(lane);
  assign linear = (ADDR_W'(rEff) * ADDR_W'(hQ) + ADDR_W'(vEff)) * ADDR_W'(wQ) + ADDR_W'(uCur);
  assign wrAddr = {linear[ADDR_W-3:0], chIdx};
  assign wrChan = chIdx;
  assign wrData = srcQ[srcIdx*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneCntQ <= '0;
      strideQ  <= '0;
      enQ      <= '0;
      maskQ    <= '0;
      uQ       <= '0;
      vQ       <= '0;
      rQ       <= '0;
      srcQ     <= '0;
      dimQ     <= '0;
      wQ       <= '0;
      hQ       <= '0;
      dQ       <= '0;
      chIdx    <= '0;
      chPos    <= '0;
      lane     <= '0;
    end else if (strobe.load) begin
      laneCntQ <= laneCntIn;
      strideQ  <= strideIn;
      enQ      <= enIn;
      maskQ    <= cmdChMask;
      uQ       <= cmdU;
      vQ       <= cmdV;
      rQ       <= cmdR;
      srcQ     <= cmdSrc;
      dimQ     <= surfDim;
      wQ       <= surfWidth;
      hQ       <= surfHeight;
      dQ       <= surfDepth;
      chIdx    <= '0;
      chPos    <= '0;
      lane     <= '0;
    end else if (strobe.step) begin
      if (!chOn || laneLast) begin
        lane  <= '0;
        chIdx <= chIdx + 2'd1;
        if (chOn) chPos <= chPos + 2'd1;
      end else begin
        lane <= lane + LANE_W'(1);
      end
    end
  end

  // bound of the whole surface, computed apart from the per-axis tests
  logic [ADDR_W-1:0] surfLimit;
  assign surfLimit = ADDR_W'(wQ) * ADDR_W'(has2 ? hQ : COORD_W'(1))
                   * ADDR_W'(has3 ? dQ : COORD_W'(1)) * ADDR_W'(4);

  // R7: an issued write always lands inside the surface
  p_addr_in_surface_r7: assert property (@(posedge clk) disable iff (!rstN)
    status.slotWrite |-> wrAddr < surfLimit);

  // R1: lanes beyond the decoded count never write
  p_lane_in_count_r1: assert property (@(posedge clk) disable iff (!rstN)
    status.slotWrite |-> CNT_W'(lane) < laneCntQ);

endmodule

// File: rtl/scatter_seq.sv
module scatter_seq
  import scatter_pkg::*;
#(
  parameter int MAX_LANES = 8,
  parameter int REG_BYTES = 32,
  parameter int COORD_W   = 8,
  parameter int DATA_W    = 32,
  localparam int REG_DW     = REG_BYTES / 4,
  localparam int STRIDE_MAX = (MAX_LANES > REG_DW) ? MAX_LANES : REG_DW,
  localparam int SRC_WORDS  = 4 * STRIDE_MAX,
  localparam int ADDR_W     = 3 * COORD_W + 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdValid,
  output logic                          cmdReady,
  input  logic [7:0]                    cmdExec,
  input  logic [MAX_LANES-1:0]          cmdLaneEn,
  input  logic [3:0]                    cmdChMask,
  input  logic [MAX_LANES*COORD_W-1:0]  cmdU,
  input  logic [MAX_LANES*COORD_W-1:0]  cmdV,
  input  logic [MAX_LANES*COORD_W-1:0]  cmdR,
  input  logic [SRC_WORDS*DATA_W-1:0]   cmdSrc,
  input  logic [1:0]                    surfDim,
  input  logic [COORD_W-1:0]            surfWidth,
  input  logic [COORD_W-1:0]            surfHeight,
  input  logic [COORD_W-1:0]            surfDepth,
  output logic                          wrValid,
  input  logic                          wrReady,
  output logic [ADDR_W-1:0]             wrAddr,
  output logic [1:0]                    wrChan,
  output logic [DATA_W-1:0]             wrData,
  output logic                          done,
  output logic                          cmdErr
);

  seqStrobe_t strobe;
  seqStatus_t status;

  scatter_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdMaskZero(cmdChMask == 4'b0000),
    .wrReady    (wrReady),
    .status     (status),
    .strobe     (strobe),
    .cmdReady   (cmdReady),
    .wrValid    (wrValid),
    .done       (done),
    .cmdErr     (cmdErr)
  );

  scatter_seq_dp #(
    .MAX_LANES(MAX_LANES),
    .REG_BYTES(REG_BYTES),
    .COORD_W  (COORD_W),
    .DATA_W   (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdExec   (cmdExec),
    .cmdLaneEn (cmdLaneEn),
    .cmdChMask (cmdChMask),
    .cmdU      (cmdU),
    .cmdV      (cmdV),
    .cmdR      (cmdR),
    .cmdSrc    (cmdSrc),
    .surfDim   (surfDim),
    .surfWidth (surfWidth),
    .surfHeight(surfHeight),
    .surfDepth (surfDepth),
    .status    (status),
    .wrAddr    (wrAddr),
    .wrChan    (wrChan),
    .wrData    (wrData)
  );

  // R9: a stalled request keeps its payload
  p_hold_payload_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid && $stable(wrAddr) && $stable(wrChan) && $stable(wrData));

  // R8: an empty mask finishes at once with the error flag and no write
  p_empty_mask_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && (cmdChMask == 4'b0000) |=> cmdErr && !wrValid);

endmodule

// File: tb/tb_scatter_seq.sv
module tb_scatter_seq;

  localparam int ML = 8;
  localparam int CW = 8;
  localparam int DW = 32;
  localparam int SW = 32;
  localparam int AW = 3 * CW + 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic              cmdReady;
  logic [7:0]        cmdExec = '0;
  logic [ML-1:0]     cmdLaneEn = '0;
  logic [3:0]        cmdChMask = '0;
  logic [ML*CW-1:0]  cmdU = '0, cmdV = '0, cmdR = '0;
  logic [SW*DW-1:0]  cmdSrc = '0;
  logic [1:0]        surfDim = '0;
  logic [CW-1:0]     surfWidth = '0, surfHeight = '0, surfDepth = '0;
  logic              wrValid;
  logic              wrReady = 1'b0;
  logic [AW-1:0]     wrAddr;
  logic [1:0]        wrChan;
  logic [DW-1:0]     wrData;
  logic              done;
  logic              cmdErr;

  scatter_seq dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdExec(cmdExec), .cmdLaneEn(cmdLaneEn), .cmdChMask(cmdChMask),
    .cmdU(cmdU), .cmdV(cmdV), .cmdR(cmdR), .cmdSrc(cmdSrc),
    .surfDim(surfDim), .surfWidth(surfWidth), .surfHeight(surfHeight),
    .surfDepth(surfDepth), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrChan(wrChan), .wrData(wrData), .done(done), .cmdErr(cmdErr)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // command under test
  logic [7:0]  tExec;
  logic [7:0]  tEn;
  logic [3:0]  tMask;
  logic [1:0]  tDim;
  logic [7:0]  tW, tH, tD;
  logic [7:0]  uA[ML], vA[ML], rA[ML];
  logic [31:0] srcA[SW];

  longint qAddr[$];
  int     qCh[$];
  longint qData[$];
  bit     lastWrite;

  // reference model of the write stream (R1..R7)
  task automatic model();
    int cnt, stride, pos, vE, rE;
    bit has2, has3, ok;
    cnt = 1 << tExec[2:0];
    if (cnt > ML) cnt = ML;
    stride = (cnt > 8) ? cnt : 8;
    pos = 0;
    lastWrite = 0;
    has2 = (tDim == 2) || (tDim == 3);
    has3 = (tDim == 3);
    qAddr.delete(); qCh.delete(); qData.delete();
    for (int c = 0; c < 4; c++) begin
      if (tMask[c]) begin
        for (int i = 0; i < cnt; i++) begin
          if (tExec[7] || tEn[i]) begin
            vE = has2 ? int'(vA[i]) : 0;
            rE = has3 ? int'(rA[i]) : 0;
            ok = (uA[i] < tW) && (!has2 || vA[i] < tH) && (!has3 || rA[i] < tD);
            if (ok) begin
              qAddr.push_back(longint'(((rE * tH + vE) * tW + uA[i]) * 4 + c));
              qCh.push_back(c);
              qData.push_back(longint'(srcA[pos * stride + i]));
              if (c == 3 && i == cnt - 1) lastWrite = 1;
            end
          end
        end
        pos++;
      end
    end
  endtask

  task automatic apply();
    cmdExec = tExec; cmdLaneEn = tEn; cmdChMask = tMask;
    surfDim = tDim; surfWidth = tW; surfHeight = tH; surfDepth = tD;
    for (int i = 0; i < ML; i++) begin
      cmdU[i*CW +: CW] = uA[i];
      cmdV[i*CW +: CW] = vA[i];
      cmdR[i*CW +: CW] = rA[i];
    end
    for (int j = 0; j < SW; j++) cmdSrc[j*DW +: DW] = srcA[j];
  endtask

  task automatic run_cmd(input string tag);
    int iter, lastX, doneAt;
    bit stalled;
    logic [AW-1:0] sA;
    logic [DW-1:0] sD;
    logic [1:0]    sC;
    model();
    apply();
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check(cmdReady == 1'b0, "R10", {tag, " busy after accept"}, cmdReady, 0);
    iter = 0; lastX = -10; doneAt = -1; stalled = 0;
    sA = '0; sD = '0; sC = '0;
    forever begin
      if (done) begin doneAt = iter; break; end
      if (iter > 600) begin
        check(0, "R10", {tag, " done timeout"}, iter, 0);
        break;
      end
      wrReady  = ($urandom % 4) != 0;
      cmdValid = ($urandom % 6) == 0;   // R10: offered while busy, must be ignored
      if (cmdValid) cmdChMask = 4'($urandom);
      #1;
      if (stalled) begin
        check(wrValid && wrAddr == sA && wrData == sD && wrChan == sC, "R9",
              {tag, " payload held"}, longint'(wrAddr), longint'(sA));
        stalled = 0;
      end
      if (wrValid && wrReady) begin
        if (qAddr.size() == 0) begin
          check(0, "R3", {tag, " unexpected write"}, longint'(wrAddr), -1);
        end else begin
          check(wrAddr == qAddr[0], "R5", {tag, " address"}, longint'(wrAddr), qAddr[0]);
          check(int'(wrChan) == qCh[0], "R3", {tag, " channel"}, longint'(wrChan), longint'(qCh[0]));
          check(longint'(wrData) == qData[0], "R4", {tag, " data"}, longint'(wrData), qData[0]);
          void'(qAddr.pop_front()); void'(qCh.pop_front()); void'(qData.pop_front());
        end
        lastX = iter;
      end else if (wrValid) begin
        stalled = 1; sA = wrAddr; sD = wrData; sC = wrChan;
      end
      @(negedge clk);
      iter++;
    end
    cmdValid = 1'b0;
    wrReady  = 1'b0;
    check(cmdErr == (tMask == 4'b0000), "R8", {tag, " error flag"}, cmdErr, (tMask == 4'b0000));
    check(qAddr.size() == 0, "R7", {tag, " missing writes"}, qAddr.size(), 0);
    if (lastWrite) check(doneAt - lastX == 1, "R10", {tag, " done timing"}, doneAt - lastX, 1);
    if (tMask == 4'b0000) check(doneAt == 0, "R10", {tag, " empty done timing"}, doneAt, 0);
    @(negedge clk);
    check(!done && cmdReady, "R10", {tag, " single done, back to idle"}, done, 0);
  endtask

  task automatic base_cmd();
    tExec = 8'h03; tEn = 8'hFF; tMask = 4'hF; tDim = 2'd3;
    tW = 8; tH = 8; tD = 8;
    for (int i = 0; i < ML; i++) begin
      uA[i] = 8'(i); vA[i] = 8'(7 - i); rA[i] = 8'(i % 3);
    end
    for (int j = 0; j < SW; j++) srcA[j] = 32'hA000_0000 + 32'(j);
  endtask

  task automatic rand_cmd();
    tExec = 8'($urandom);
    if ($urandom % 5 != 0) tExec[2:0] = 3'($urandom % 4);
    tEn   = 8'($urandom);
    tMask = ($urandom % 10 == 0) ? 4'h0 : 4'($urandom);
    tDim  = 2'($urandom);
    tW = 8'(1 + $urandom % 6); tH = 8'(1 + $urandom % 6); tD = 8'(1 + $urandom % 6);
    for (int i = 0; i < ML; i++) begin
      uA[i] = 8'($urandom % 8); vA[i] = 8'($urandom % 8); rA[i] = 8'($urandom % 8);
    end
    for (int j = 0; j < SW; j++) srcA[j] = $urandom;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual 200000 cycles expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    check(!wrValid && !done && !cmdErr, "R10", "outputs quiet in reset", wrValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdReady && !wrValid && !done, "R10", "idle after reset", cmdReady, 1);

    // R3 R5: all channels, all lanes, 3D surface
    base_cmd(); run_cmd("R3 full");

    // R8: empty channel mask
    base_cmd(); tMask = 4'h0; run_cmd("R8 empty");

    // R4: sparse mask G and A with holes in the lane enables
    base_cmd(); tMask = 4'b1010; tEn = 8'b1011_0110; run_cmd("R4 sparse");

    // R6: 1D surface, V and R far out of range but ignored
    base_cmd(); tDim = 2'd1; tH = 1; tD = 1;
    for (int i = 0; i < ML; i++) begin vA[i] = 8'd200; rA[i] = 8'd201; end
    run_cmd("R6 1d");

    // R6: 2D surface, R out of range but ignored
    base_cmd(); tDim = 2'd2; tD = 1;
    for (int i = 0; i < ML; i++) rA[i] = 8'd250;
    run_cmd("R6 2d");

    // R7: some U, V and R outside the surface
    base_cmd(); tW = 4; tH = 5; tD = 2; run_cmd("R7 oob");

    // R1 R4: single lane, four lanes and an over-range code
    base_cmd(); tExec = 8'h00; tMask = 4'b0110; run_cmd("R1 one lane");
    base_cmd(); tExec = 8'h02; tMask = 4'b1101; run_cmd("R1 four lanes");
    base_cmd(); tExec = 8'h07; tMask = 4'b1001; run_cmd("R1 clamp");

    // R2: no-mask bit overrides a zero enable vector
    base_cmd(); tExec = 8'h83; tEn = 8'h00; tMask = 4'b0100; run_cmd("R2 nomask");
    base_cmd(); tExec = 8'h03; tEn = 8'h00; tMask = 4'b0100; run_cmd("R2 all off");

    for (int n = 0; n < 150; n++) begin
      rand_cmd();
      run_cmd("random");
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule